// File: doc/BRIEF.md
# LIN/UART Controller Register Bank

This block holds the software-visible control and status registers of a LIN/UART serial controller. A simple synchronous register bus writes a byte on a single clock edge. Reads are combinational from the address. The protocol engine is not part of this block. It reports events through one-cycle set pulses, one for each completion flag and one for each error bit. It also drives the engine-state index and the busy indication, which the bank mirrors read-only.

The bank has two access modes, chosen by the `dbg_halt` pin:

- **Run mode.** Event flags are write-one-to-clear. The error summary is a derived read-only bit.
- **Debug-halt mode.** A debugger can write the completion flags, the error summary and the error bits directly. Writing the summary forces every error bit to the written value.

Two rules apply in both modes. The bit-timing field is locked unless its resynchronisation-disable bit is already set. The identifier register returns two parity bits computed live from the stored identifier.

Register map (4-bit address, 8-bit data):

| Addr | Register | Contents |
|------|----------|----------|
| 0 | control | bit7 software reset, bits 6:0 read/write |
| 1 | status | bit0 receive-done, bit1 transmit-done, bit2 error summary, bit3 busy, bits 6:4 state index, bit7 reads 0 |
| 2 | enable | read/write |
| 3 | error | error flags |
| 4 | baud low byte | read/write |
| 5 | baud high byte | read/write |
| 6 | data length | read/write |
| 7 | identifier | bits 5:0 identifier, bits 7:6 parity |
| 8 | select | read/write |
| 9 to 15 | unmapped | read 0 |

The bit-timing register sits at address 10: bit7 is the resynchronisation-disable bit, bits 5:0 are the timing field, and bit6 reads 0. Address 10 is therefore mapped; only addresses 9 and 11 to 15 read 0.

There is no streaming data path in this block, so no pin uses valid/ready. Every pin is a plain level or pulse.

Top module: `lin_regbank`

## Requirements
- R1: Writing 1 to control bit7 drives `sw_reset_o` high for exactly one cycle after the write edge. Control bit7 reads 1 during that cycle and 0 afterwards. Control bits 6:0 are plain read/write.
- R2: Status bit2 and `err_flag_o` equal the OR of all bits of the error register (address 3).
- R3: In debug mode, a write to status sets every error bit to the value written to bit2, whether 0 or 1.
- R4: In debug mode, a write to status loads bits 1:0 directly into the completion flags. A write to the error register loads it directly.
- R5: In run mode, completion flags and error bits clear when 1 is written to their position. A written 0 leaves them unchanged. A status write never changes the error bits.
- R6: Status bits 6:4 show `state_idx` and bit3 shows `busy` in both modes. Writes do not change them.
- R7: Address 10 is the bit-timing register. The resynchronisation-disable bit (bit7) is always writable. The timing field (bits 5:0) takes a write only while the stored bit7 is already 1; otherwise the write is ignored. Bit6 reads 0.
- R8: Identifier bits 5:0 are read/write. Bits 7:6 ignore writes and read P1,P0, where P0 = I0^I1^I2^I4 and P1 = ~(I1^I3^I4^I5).
- R9: When a set pulse and a clearing or zero write hit the same flag in the same cycle, the flag ends up set.
- R10: The enable, baud low/high, data-length and select registers are plain read/write in both modes. All registers reset to zero.
- R11: Addresses 9 and 11 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| dbg_halt | input | 1 | 1 selects debug-halt access rules |
| bus_wr | input | 1 | write strobe, one byte per cycle |
| bus_addr | input | 4 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | combinational read data for `bus_addr` |
| set_rx_done | input | 1 | set pulse for the receive-done flag |
| set_tx_done | input | 1 | set pulse for the transmit-done flag |
| set_err | input | 8 | set pulses, one per error bit |
| state_idx | input | 3 | engine state index, mirrored in status |
| busy | input | 1 | engine busy, mirrored in status |
| sw_reset_o | output | 1 | one-cycle software reset pulse |
| ctrl_o | output | 7 | control bits 6:0 |
| enable_o | output | 8 | enable register |
| baud_o | output | 16 | baud divisor {high, low} |
| dlen_o | output | 8 | data-length register |
| sel_o | output | 8 | select register |
| timing_o | output | 6 | bit-timing field |
| resync_dis_o | output | 1 | resynchronisation-disable bit |
| ident_o | output | 6 | identifier |
| parity_o | output | 2 | live parity {P1,P0} |
| err_flag_o | output | 1 | error summary |

## Verification
The bench targets the same-cycle collision of a set pulse and a clearing write. A design that let software win would lose an event and read the flag as 0.

Mode switching is checked by writing the same values in run and in debug mode:
- A bank that ignored the mode would clear a flag on a written 1 when a debugger meant to set it.
- A bank that ignored the mode would leave error bits alone when the summary is forced.

The timing lock is checked before and after the disable bit is set. A design that tested the incoming bit instead of the stored bit would accept a combined write.

Identifiers with the parity terms at both extremes are written. A parity bit off by a term, or P1 not inverted, shows up on at least one of them.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENA    = 4'd2;
  localparam logic [ADDR_W-1:0] A_ERR    = 4'd3;
  localparam logic [ADDR_W-1:0] A_BAUDL  = 4'd4;
  localparam logic [ADDR_W-1:0] A_BAUDH  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DLEN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_IDENT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_SEL    = 4'd8;
  localparam logic [ADDR_W-1:0] A_TIMING = 4'd10;

  // status bit positions
  localparam int ST_RX   = 0;
  localparam int ST_TX   = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_BUSY = 3;
  localparam int ST_IDX  = 4;
endpackage

// File: rtl/lrb_rwreg.sv
module lrb_rwreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/lrb_flagbank.sv
// Event flags: hardware set pulse beats any write; run mode clears on 1,
// debug mode loads the written value.
module lrb_flagbank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dbg,
  input  logic         wr_hit,
  input  logic [N-1:0] wval,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set[i])     q[i] <= 1'b1;
      else if (wr_hit) begin
        if (dbg)           q[i] <= wval[i];
        else if (wval[i])  q[i] <= 1'b0;
      end
    end

    // R9: a set pulse always leaves the flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);

    // R5: run-mode write of 0 without a set pulse keeps the flag
    p_run_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !dbg && !wval[i] && !set[i]) |=> $stable(q[i]));

    // R4: debug write without a set pulse loads the value
    p_dbg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && dbg && !set[i]) |=> (q[i] == $past(wval[i])));
  end
endmodule

// File: rtl/lrb_parity.sv
module lrb_parity (
  input  logic [5:0] ident,
  output logic [1:0] par
);
  always_comb begin
    par[0] = ident[0] ^ ident[1] ^ ident[2] ^ ident[4];
    par[1] = ~(ident[1] ^ ident[3] ^ ident[4] ^ ident[5]);
  end
endmodule

// File: rtl/lin_regbank.sv
module lin_regbank
  import lrb_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              set_rx_done,
  input  logic              set_tx_done,
  input  logic [ERR_W-1:0]  set_err,
  input  logic [2:0]        state_idx,
  input  logic              busy,
  output logic              sw_reset_o,
  output logic [6:0]        ctrl_o,
  output logic [7:0]        enable_o,
  output logic [15:0]       baud_o,
  output logic [7:0]        dlen_o,
  output logic [7:0]        sel_o,
  output logic [5:0]        timing_o,
  output logic              resync_dis_o,
  output logic [5:0]        ident_o,
  output logic [1:0]        parity_o,
  output logic              err_flag_o
);
  localparam int NPLAIN = 5;

  logic wr_ctrl, wr_stat, wr_err, wr_ident, wr_timing;
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign wr_err    = bus_wr && (bus_addr == A_ERR);
  assign wr_ident  = bus_wr && (bus_addr == A_IDENT);
  assign wr_timing = bus_wr && (bus_addr == A_TIMING);

  // plain read/write registers (R10)
  logic [ADDR_W-1:0] plain_addr [NPLAIN];
  logic [DATA_W-1:0] plain_q    [NPLAIN];
  assign plain_addr[0] = A_ENA;
  assign plain_addr[1] = A_BAUDL;
  assign plain_addr[2] = A_BAUDH;
  assign plain_addr[3] = A_DLEN;
  assign plain_addr[4] = A_SEL;

  for (genvar k = 0; k < NPLAIN; k++) begin : g_plain
    lrb_rwreg #(.W(DATA_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(bus_wr && (bus_addr == plain_addr[k])),
      .d(bus_wdata), .q(plain_q[k])
    );
  end
  assign enable_o = plain_q[0];
  assign baud_o   = {plain_q[2], plain_q[1]};
  assign dlen_o   = plain_q[3];
  assign sel_o    = plain_q[4];

  // control: bits 6:0 read/write, bit7 self-clearing reset (R1)
  lrb_rwreg #(.W(7)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(wr_ctrl),
    .d(bus_wdata[6:0]), .q(ctrl_o)
  );
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_reset_o <= 1'b0;
    else        sw_reset_o <= wr_ctrl && bus_wdata[7];
  end

  // completion flags (R4, R5, R9)
  logic [1:0] done_q;
  lrb_flagbank #(.N(2)) u_done (
    .clk(clk), .rst_n(rst_n), .dbg(dbg_halt), .wr_hit(wr_stat),
    .wval(bus_wdata[ST_TX:ST_RX]),
    .set({set_tx_done, set_rx_done}),
    .q(done_q)
  );

  // error flags (R2, R3, R4, R5, R9)
  logic             err_hit;
  logic [ERR_W-1:0] err_val;
  logic [ERR_W-1:0] err_q;
  assign err_hit = wr_err || (dbg_halt && wr_stat);
  assign err_val = wr_err ? bus_wdata[ERR_W-1:0] : {ERR_W{bus_wdata[ST_ERR]}};
  lrb_flagbank #(.N(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .dbg(dbg_halt), .wr_hit(err_hit),
    .wval(err_val), .set(set_err), .q(err_q)
  );
  assign err_flag_o = |err_q;

  // bit timing with write lock (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resync_dis_o <= 1'b0;
      timing_o     <= '0;
    end else if (wr_timing) begin
      resync_dis_o <= bus_wdata[7];
      if (resync_dis_o) timing_o <= bus_wdata[5:0];
    end
  end

  // identifier and live parity (R8)
  lrb_rwreg #(.W(6)) u_ident (
    .clk(clk), .rst_n(rst_n), .we(wr_ident),
    .d(bus_wdata[5:0]), .q(ident_o)
  );
  lrb_parity u_par (.ident(ident_o), .par(parity_o));

  // read mux (R6, R11)
  logic [7:0] stat_rd;
  always_comb begin
    stat_rd = '0;
    stat_rd[ST_RX]             = done_q[0];
    stat_rd[ST_TX]             = done_q[1];
    stat_rd[ST_ERR]            = err_flag_o;
    stat_rd[ST_BUSY]           = busy;
    stat_rd[ST_IDX+2:ST_IDX]   = state_idx;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {sw_reset_o, ctrl_o};
      A_STAT:   bus_rdata = stat_rd;
      A_ENA:    bus_rdata = plain_q[0];
      A_ERR:    bus_rdata = 8'(err_q);
      A_BAUDL:  bus_rdata = plain_q[1];
      A_BAUDH:  bus_rdata = plain_q[2];
      A_DLEN:   bus_rdata = plain_q[3];
      A_IDENT:  bus_rdata = {parity_o, ident_o};
      A_SEL:    bus_rdata = plain_q[4];
      A_TIMING: bus_rdata = {resync_dis_o, 1'b0, timing_o};
      default:  bus_rdata = '0;
    endcase
  end

  // R1: reset pulse lasts a single cycle
  p_swrst_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_o |=> !sw_reset_o);

  // R2: any error set pulse raises the summary next cycle
  p_err_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_err) |=> err_flag_o);

  // R3: debug summary clear with no set pulses empties the error bits
  p_dbg_force_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && wr_stat && !bus_wdata[ST_ERR] && !(|set_err)) |=> !err_flag_o);

  // R7: locked timing field ignores writes
  p_timing_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_timing && !resync_dis_o) |=> $stable(timing_o));
endmodule

// File: tb/lin_regbank_tb_top.sv
`timescale 1ns/1ps
module lin_regbank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_halt = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic set_rx_done = 1'b0, set_tx_done = 1'b0;
  logic [7:0] set_err = '0;
  logic [2:0] state_idx = '0;
  logic busy = 1'b0;
  logic sw_reset_o;
  logic [6:0] ctrl_o;
  logic [7:0] enable_o, dlen_o, sel_o;
  logic [15:0] baud_o;
  logic [5:0] timing_o, ident_o;
  logic resync_dis_o, err_flag_o;
  logic [1:0] parity_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lin_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_rx_done(set_rx_done), .set_tx_done(set_tx_done), .set_err(set_err),
    .state_idx(state_idx), .busy(busy), .sw_reset_o(sw_reset_o),
    .ctrl_o(ctrl_o), .enable_o(enable_o), .baud_o(baud_o), .dlen_o(dlen_o),
    .sel_o(sel_o), .timing_o(timing_o), .resync_dis_o(resync_dis_o),
    .ident_o(ident_o), .parity_o(parity_o), .err_flag_o(err_flag_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] with_par(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  task automatic t_reset_state;
    logic [7:0] v;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      if (a == 7) chk("R10 reset ident", 16'(v), 16'h0080);
      else        chk("R10 reset zero", 16'(v), 16'h0000);
    end
    chk("R1 reset pulse low", 16'(sw_reset_o), 16'h0);
  endtask

  task automatic t_sw_reset;
    logic [7:0] v;
    wr(4'd0, 8'h95);
    rd(4'd0, v);
    chk("R1 bit7 reads 1 one cycle", 16'(v), 16'h0095);
    chk("R1 pulse high", 16'(sw_reset_o), 16'h1);
    @(negedge clk);
    rd(4'd0, v);
    chk("R1 bit7 clears", 16'(v), 16'h0015);
    chk("R1 pulse gone", 16'(sw_reset_o), 16'h0);
  endtask

  task automatic t_plain;
    logic [7:0] v;
    wr(4'd2, 8'hA5); wr(4'd4, 8'h34); wr(4'd5, 8'h12);
    wr(4'd6, 8'h08); wr(4'd8, 8'h3C);
    rd(4'd2, v); chk("R10 enable", 16'(v), 16'h00A5);
    chk("R10 baud", baud_o, 16'h1234);
    rd(4'd6, v); chk("R10 dlen", 16'(v), 16'h0008);
    dbg_halt = 1'b1;
    wr(4'd8, 8'hC3);
    rd(4'd8, v); chk("R10 sel debug", 16'(v), 16'h00C3);
    dbg_halt = 1'b0;
    rd(4'd9, v);  chk("R11 addr9", 16'(v), 16'h0);
    rd(4'd15, v); chk("R11 addr15", 16'(v), 16'h0);
  endtask

  task automatic t_ro_status;
    logic [7:0] v;
    state_idx = 3'd5; busy = 1'b1;
    wr(4'd1, 8'h00);
    rd(4'd1, v); chk("R6 mirror", 16'(v), 16'h0058);
    dbg_halt = 1'b1;
    wr(4'd1, 8'h00);
    rd(4'd1, v); chk("R6 debug write ignored", 16'(v), 16'h0058);
    dbg_halt = 1'b0; state_idx = 3'd0; busy = 1'b0;
  endtask

  task automatic t_run_flags;
    logic [7:0] v;
    @(negedge clk); set_rx_done = 1; set_tx_done = 1; set_err = 8'h24;
    @(negedge clk); set_rx_done = 0; set_tx_done = 0; set_err = 8'h00;
    rd(4'd1, v); chk("R2 summary set", 16'(v), 16'h0007);
    wr(4'd1, 8'h00);
    rd(4'd1, v); chk("R5 zero write keeps", 16'(v), 16'h0007);
    wr(4'd1, 8'h05);
    rd(4'd1, v); chk("R5 w1c rx, summary untouched", 16'(v), 16'h0006);
    rd(4'd3, v); chk("R5 errors kept", 16'(v), 16'h0024);
    wr(4'd3, 8'h04);
    rd(4'd3, v); chk("R5 err w1c", 16'(v), 16'h0020);
    chk("R2 summary one bit", 16'(err_flag_o), 16'h1);
    wr(4'd3, 8'h20);
    rd(4'd1, v); chk("R2 summary clears", 16'(v), 16'h0002);
    wr(4'd1, 8'h02);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    wr(4'd1, 8'h00);
    @(negedge clk);
    set_rx_done = 1; set_err = 8'h01;
    bus_wr = 1; bus_addr = 4'd3; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 0; set_err = 8'h00;
    bus_addr = 4'd1; bus_wdata = 8'h01; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; set_rx_done = 0;
    rd(4'd1, v); chk("R9 rx set beats clear", 16'(v & 8'h01), 16'h0001);
    rd(4'd3, v); chk("R9 err set beats clear", 16'(v), 16'h0001);
    wr(4'd1, 8'h01); wr(4'd3, 8'hFF);
  endtask

  task automatic t_debug;
    logic [7:0] v;
    dbg_halt = 1'b1;
    wr(4'd1, 8'h07);
    rd(4'd3, v); chk("R3 summary 1 sets all", 16'(v), 16'h00FF);
    rd(4'd1, v); chk("R4 direct flags", 16'(v), 16'h0007);
    wr(4'd1, 8'h01);
    rd(4'd1, v); chk("R4 direct load, R3 clear", 16'(v), 16'h0001);
    rd(4'd3, v); chk("R3 summary 0 clears all", 16'(v), 16'h0000);
    wr(4'd3, 8'h5A);
    rd(4'd3, v); chk("R4 err direct", 16'(v), 16'h005A);
    dbg_halt = 1'b0;
    wr(4'd3, 8'h00);
    rd(4'd3, v); chk("R5 run zero no effect", 16'(v), 16'h005A);
    wr(4'd3, 8'hFF); wr(4'd1, 8'h03);
    rd(4'd1, v); chk("R5 all cleared", 16'(v), 16'h0000);
  endtask

  task automatic t_timing;
    logic [7:0] v;
    wr(4'd10, 8'hBF);
    rd(4'd10, v); chk("R7 locked field, bit7 set", 16'(v), 16'h0080);
    wr(4'd10, 8'hEA);
    rd(4'd10, v); chk("R7 unlocked write", 16'(v), 16'h00AA);
    wr(4'd10, 8'h15);
    rd(4'd10, v); chk("R7 still accepts on clear", 16'(v), 16'h0015);
    wr(4'd10, 8'h3F);
    rd(4'd10, v); chk("R7 locked again", 16'(v), 16'h0015);
  endtask

  task automatic t_ident;
    logic [7:0] v;
    logic [5:0] ids [4] = '{6'h00, 6'h3F, 6'h15, 6'h2A};
    foreach (ids[i]) begin
      wr(4'd7, {2'b11, ids[i]});
      rd(4'd7, v); chk("R8 ident parity", 16'(v), 16'(with_par(ids[i])));
    end
    wr(4'd7, 8'h01);
    rd(4'd7, v); chk("R8 ident single bit", 16'(v), 16'(with_par(6'h01)));
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_sw_reset();
    t_plain();
    t_ro_status();
    t_run_flags();
    t_set_wins();
    t_debug();
    t_timing();
    t_ident();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule